// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a tree of descriptors stored in memory. A request brings the virtual address, the base of the root table, a supervisor flag and a write flag. The walker then reads descriptors one word at a time over a simple memory port. At each level it decodes the two-bit type code of the descriptor, which decides what happens next. The walk either goes down one level, ends on a page, or ends with a fault.

The root level (A) holds 8-byte long descriptors. A long descriptor is an attribute word followed by an address word. The two lower levels (B and C) hold 4-byte short descriptors. A page may end the walk at any level, and the higher the level the larger the region it maps. Along the way the walker keeps the used and modified flags of the descriptors in memory up to date, with one word write-back per descriptor. It returns the result as a one-cycle response that carries the physical address, a fault code and the level at which the walk stopped.

Top module: `ptw_top`

## Requirements
- R1: The virtual address is split into four fields: index A is bits 31..25, index B is bits 24..19, index C is bits 18..13, and the offset is bits 12..0. The descriptor address is the table base with bits 3..0 cleared, plus the index times 8 at level A or the index times 4 at levels B and C. The level A table base is the root input, and the next table base comes from bits 31..4 of the address word.
- R2: A level A descriptor takes two reads: first the attribute word at the descriptor address, then the address word at that address plus 4. Levels B and C take one read each, and that single word serves as both attribute and address.
- R3: A type code of 0 (in bits 1..0) ends the walk with fault code 1, invalid. A table code (2 or 3) at level C also ends the walk with fault code 1. The reported level is 0 for A, 1 for B and 2 for C.
- R4: Type code 1 (page) ends the walk with fault code 0. The physical address is the page base (address word bits 31..8, low bits zero) plus the virtual address bits 24..0 at level A, bits 18..0 at level B, or bits 12..0 at level C.
- R5: If a write request meets a descriptor with bit 2 (write-protect) set, the walk ends with fault code 2, protect.
- R6: If a level A attribute word has bit 8 (supervisor only) set and the request is not from supervisor mode, the walk ends with fault code 3, privilege. This check takes precedence over the protect check.
- R7: A descriptor that passes its checks with bit 3 (used) clear is written back once, with bit 3 set, before the walk goes on. For level A this is the attribute word. A descriptor with bit 3 already set is not written.
- R8: When a write request ends on a page, bit 4 (modified) of that page descriptor is set. This happens in the same single write that sets the used bit. A read request never sets bit 4.
- R9: A descriptor that causes a fault is never written.
- R10: req_ready_o is high only while idle, and no memory request is made while idle. The response strobe lasts exactly one cycle. A memory request holds its address and direction until mem_rvalid_i answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a translation (taken while req_ready_o is high) |
| req_ready_o | output | 1 | Walker idle |
| req_va_i | input | 32 | Virtual address |
| req_root_i | input | 32 | Base of the level A table |
| req_super_i | input | 1 | Request is from supervisor mode |
| req_write_i | input | 1 | Request is a write |
| mem_req_o | output | 1 | Memory access pending |
| mem_we_o | output | 1 | Pending access is a write |
| mem_addr_o | output | 32 | Word address of the access |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rvalid_i | input | 1 | Access completed (read data valid for reads) |
| mem_rdata_i | input | 32 | Read data |
| resp_valid_o | output | 1 | Result strobe, one cycle |
| resp_pa_o | output | 32 | Physical address (valid when fault is 0) |
| resp_fault_o | output | 2 | 0 none, 1 invalid, 2 protect, 3 privilege |
| resp_level_o | output | 2 | Level where the walk stopped: 0 A, 1 B, 2 C |

## Verification
The embedded assertions check the following on every cycle:
- memory accesses are word-aligned and held stable until answered;
- the response strobe is a single-cycle pulse;
- nothing reaches memory while the walker is idle;
- every write-back carries the used bit;
- a faulting response follows a read, never a write-back.

Some behaviour is visible only through the bench's scenarios, which use a model memory holding real tables. These cover:
- the order of descriptor addresses;
- the offset width chosen by the level of an early page;
- fault precedence;
- the exact number of write-backs and the contents of the descriptor words after each walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int unsigned AW       = 32;
  parameter int unsigned IDX_A_W  = 7;
  parameter int unsigned IDX_B_W  = 6;
  parameter int unsigned IDX_C_W  = 6;
  parameter int unsigned OFF_W    = 13;

  localparam int unsigned LSB_C = OFF_W;
  localparam int unsigned LSB_B = LSB_C + IDX_C_W;
  localparam int unsigned LSB_A = LSB_B + IDX_B_W;

  localparam int unsigned LONG_SH        = 3;
  localparam int unsigned SHORT_SH       = 2;
  localparam int unsigned TABLE_BASE_LSB = 4;
  localparam int unsigned PAGE_BASE_LSB  = 8;
  localparam int unsigned BIT_WP         = 2;
  localparam int unsigned BIT_USED       = 3;
  localparam int unsigned BIT_MOD        = 4;
  localparam int unsigned BIT_SUPER      = 8;

  typedef enum logic [1:0] {DT_INV = 2'd0, DT_PAGE = 2'd1, DT_SHORT = 2'd2, DT_LONG = 2'd3} dtype_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_INVALID = 2'd1, FLT_PROT = 2'd2, FLT_PRIV = 2'd3} fault_e;
  typedef enum logic [1:0] {LVL_A = 2'd0, LVL_B = 2'd1, LVL_C = 2'd2} level_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  level_e          lvl_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:LSB_C] va_i,
  output logic [AW-1:0]   addr_o
);
  localparam logic [AW-1:0] TBL_MASK = ~AW'((1 << TABLE_BASE_LSB) - 1);

  logic [AW-1:0] tbl;

  always_comb begin
    tbl = base_i & TBL_MASK;
    unique case (lvl_i)
      LVL_A:   addr_o = tbl + (AW'(va_i[AW-1:LSB_A])    << LONG_SH);
      LVL_B:   addr_o = tbl + (AW'(va_i[LSB_A-1:LSB_B]) << SHORT_SH);
      default: addr_o = tbl + (AW'(va_i[LSB_B-1:LSB_C]) << SHORT_SH);
    endcase
  end
endmodule

// File: rtl/ptw_pa_gen.sv
module ptw_pa_gen
  import ptw_pkg::*;
(
  input  level_e        lvl_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] va_i,
  output logic [AW-1:0] pa_o
);
  localparam logic [AW-1:0] PAGE_MASK = ~AW'((1 << PAGE_BASE_LSB) - 1);
  localparam logic [AW-1:0] OFF_A     = AW'((64'd1 << LSB_A) - 1);
  localparam logic [AW-1:0] OFF_B     = AW'((64'd1 << LSB_B) - 1);
  localparam logic [AW-1:0] OFF_C     = AW'((64'd1 << LSB_C) - 1);

  logic [AW-1:0] off_mask;

  always_comb begin
    unique case (lvl_i)
      LVL_A:   off_mask = OFF_A;
      LVL_B:   off_mask = OFF_B;
      default: off_mask = OFF_C;
    endcase
    pa_o = (base_i & PAGE_MASK) + (va_i & off_mask);
  end
endmodule

// File: rtl/ptw_desc_check.sv
module ptw_desc_check
  import ptw_pkg::*;
(
  input  level_e     lvl_i,
  input  logic [1:0] dt_i,
  input  logic       wp_i,
  input  logic       super_only_i,
  input  logic       super_i,
  input  logic       write_i,
  output fault_e     fault_o
);
  dtype_e dt;
  assign dt = dtype_e'(dt_i);

  // precedence: type, then privilege, then protect
  always_comb begin
    if (dt == DT_INV || (lvl_i == LVL_C && dt != DT_PAGE))
      fault_o = FLT_INVALID;
    else if (lvl_i == LVL_A && super_only_i && !super_i)
      fault_o = FLT_PRIV;
    else if (write_i && wp_i)
      fault_o = FLT_PROT;
    else
      fault_o = FLT_NONE;
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_va_i,
  input  logic [31:0]   req_root_i,
  input  logic          req_super_i,
  input  logic          req_write_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          resp_valid_o,
  output logic [31:0]   resp_pa_o,
  output logic [1:0]    resp_fault_o,
  output logic [1:0]    resp_level_o
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_RD2, S_CHK, S_WB, S_RESP} state_e;

  state_e        state_q;
  level_e        lvl_q;
  fault_e        fault_q, rd_fault;
  logic [AW-1:0] va_q, daddr_q, attr_q, base_q, pa_q;
  logic          super_q, write_q;

  level_e        ag_lvl;
  logic [AW-1:0] ag_base, ag_va, ag_addr, pa_calc;
  logic          is_page, need_wb;

  assign ag_lvl  = (state_q == S_IDLE) ? LVL_A : level_e'(lvl_q + 2'd1);
  assign ag_base = (state_q == S_IDLE) ? req_root_i : base_q;
  assign ag_va   = (state_q == S_IDLE) ? req_va_i : va_q;

  ptw_addr_gen u_addr (
    .lvl_i  (ag_lvl),
    .base_i (ag_base),
    .va_i   (ag_va[AW-1:LSB_C]),
    .addr_o (ag_addr)
  );

  ptw_pa_gen u_pa (
    .lvl_i  (lvl_q),
    .base_i (base_q),
    .va_i   (va_q),
    .pa_o   (pa_calc)
  );

  ptw_desc_check u_chk (
    .lvl_i        (lvl_q),
    .dt_i         (mem_rdata_i[1:0]),
    .wp_i         (mem_rdata_i[BIT_WP]),
    .super_only_i (mem_rdata_i[BIT_SUPER]),
    .super_i      (super_q),
    .write_i      (write_q),
    .fault_o      (rd_fault)
  );

  assign is_page = (dtype_e'(attr_q[1:0]) == DT_PAGE);
  assign need_wb = !attr_q[BIT_USED] || (is_page && write_q && !attr_q[BIT_MOD]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lvl_q   <= LVL_A;
      fault_q <= FLT_NONE;
      va_q    <= '0;
      daddr_q <= '0;
      attr_q  <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      super_q <= 1'b0;
      write_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          super_q <= req_super_i;
          write_q <= req_write_i;
          lvl_q   <= LVL_A;
          daddr_q <= ag_addr;
          pa_q    <= '0;
          state_q <= S_RD;
        end
        S_RD: if (mem_rvalid_i) begin
          attr_q <= mem_rdata_i;
          if (rd_fault != FLT_NONE) begin
            fault_q <= rd_fault;
            state_q <= S_RESP;
          end else if (lvl_q == LVL_A) begin
            state_q <= S_RD2;
          end else begin
            base_q  <= mem_rdata_i;
            state_q <= S_CHK;
          end
        end
        S_RD2: if (mem_rvalid_i) begin
          base_q  <= mem_rdata_i;
          state_q <= S_CHK;
        end
        S_CHK, S_WB: if (state_q == S_CHK ? !need_wb : mem_rvalid_i) begin
          if (state_q == S_CHK && need_wb) begin
            state_q <= S_WB;
          end else if (is_page) begin
            pa_q    <= pa_calc;
            fault_q <= FLT_NONE;
            state_q <= S_RESP;
          end else begin
            lvl_q   <= ag_lvl;
            daddr_q <= ag_addr;
            state_q <= S_RD;
          end
        end else if (state_q == S_CHK) begin
          state_q <= S_WB;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == S_IDLE);
  assign mem_req_o    = (state_q == S_RD) || (state_q == S_RD2) || (state_q == S_WB);
  assign mem_we_o     = (state_q == S_WB);
  assign mem_addr_o   = (state_q == S_RD2) ? daddr_q + AW'(4) : daddr_q;
  assign mem_wdata_o  = attr_q | (AW'(1) << BIT_USED)
                      | ((is_page && write_q) ? (AW'(1) << BIT_MOD) : '0);
  assign resp_valid_o = (state_q == S_RESP);
  assign resp_pa_o    = pa_q;
  assign resp_fault_o = fault_q;
  assign resp_level_o = lvl_q;

  // R1
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
  // R10
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R10
  resp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !resp_valid_o);
  // R7
  wb_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[BIT_USED]);
  // R9
  fault_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_fault_o != 2'd0 |-> $past(mem_req_o && !mem_we_o));
endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_super = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0, req_root = 32'h1000;
  logic        req_ready, mem_req, mem_we, mem_rvalid, resp_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, resp_pa;
  logic [1:0]  resp_fault, resp_level;

  ptw_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_root_i(req_root), .req_super_i(req_super), .req_write_i(req_write),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .resp_valid_o(resp_valid), .resp_pa_o(resp_pa),
    .resp_fault_o(resp_fault), .resp_level_o(resp_level)
  );

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [$];

  typedef struct { logic [31:0] pa; logic [1:0] fl; logic [1:0] lv; string tag; } exp_t;
  exp_t exp_q [$];

  // memory model: one cycle per access
  always @(posedge clk) begin
    if (mem_rvalid) mem_rvalid <= 1'b0;
    else if (mem_req) begin
      mem_rvalid <= 1'b1;
      if (mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt++; end
      else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        rd_log.push_back(mem_addr);
      end
    end
  end
  initial begin mem_rvalid = 1'b0; mem_rdata = '0; end

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // monitor
  always @(negedge clk) if (rst_n && resp_valid) begin
    exp_t e;
    if (exp_q.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10 unexpected response actual=1 expected=0");
    end else begin
      e = exp_q.pop_front();
      check(32'(resp_fault), 32'(e.fl), {e.tag, " fault"});
      check(32'(resp_level), 32'(e.lv), {e.tag, " level"});
      if (e.fl == 2'd0) check(resp_pa, e.pa, {e.tag, " pa"});
    end
  end

  function automatic logic [31:0] va_of(int a, int b, int c, int off);
    return (32'(a) << 25) | (32'(b) << 19) | (32'(c) << 13) | 32'(off);
  endfunction

  task automatic walk(logic [31:0] va, bit sup, bit wr,
                      logic [31:0] pa, logic [1:0] fl, logic [1:0] lv, string tag);
    exp_t e;
    e.pa = pa; e.fl = fl; e.lv = lv; e.tag = tag;
    exp_q.push_back(e);
    rd_log.delete();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_va = va; req_super = sup; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w0;
    logic [31:0] va1, va2, va3, vp;
    // tables
    mem[32'h1018] = 32'h0000_0002; mem[32'h101C] = 32'h0000_2000;
    mem[32'h2014] = 32'h0000_3002;
    mem[32'h301C] = 32'h00AB_C001;
    mem[32'h3028] = 32'h0000_0002;
    mem[32'h1050] = 32'h0000_0009; mem[32'h1054] = 32'h4600_0000;
    mem[32'h1020] = 32'h0000_000A; mem[32'h1024] = 32'h0000_5000;
    mem[32'h5008] = 32'h0078_0009;
    mem[32'h500C] = 32'h0077_000D;
    mem[32'h1030] = 32'h0000_010A; mem[32'h1034] = 32'h0000_2000;
    mem[32'h1038] = 32'h0000_010E; mem[32'h103C] = 32'h0000_2000;
    mem[32'h1058] = 32'h0000_0001; mem[32'h105C] = 32'h6000_0000;

    repeat (3) @(negedge clk);
    check(32'(req_ready), 1, "R10 reset ready");
    check(32'(resp_valid), 0, "R10 reset resp");
    check(32'(mem_req), 0, "R10 reset mem_req");
    rst_n = 1'b1;
    @(negedge clk);

    va1 = va_of(3, 5, 7, 'h123);
    w0 = wr_cnt;
    walk(va1, 0, 0, 32'h00AB_C123, 2'd0, 2'd2, "R4 level C page");
    check(rd_log[0], 32'h1018, "R1 A address");
    check(rd_log[1], 32'h101C, "R2 A second word");
    check(rd_log[2], 32'h2014, "R1 B address");
    check(rd_log[3], 32'h301C, "R1 C address");
    check(32'(wr_cnt - w0), 3, "R7 used writes");
    check(mem_rd(32'h1018), 32'h0000_000A, "R7 A used set");
    check(mem_rd(32'h2014), 32'h0000_300A, "R7 B used set");
    check(mem_rd(32'h301C), 32'h00AB_C009, "R8 read leaves modified");

    w0 = wr_cnt;
    walk(va1, 0, 1, 32'h00AB_C123, 2'd0, 2'd2, "R8 write walk");
    check(32'(wr_cnt - w0), 1, "R8 single write");
    check(mem_rd(32'h301C), 32'h00AB_C019, "R8 modified set");

    va2 = (32'd10 << 25) | 32'h0123456;
    w0 = wr_cnt;
    walk(va2, 0, 0, 32'h4612_3456, 2'd0, 2'd0, "R4 level A page");
    check(rd_log[0], 32'h1050, "R2 attr first");
    check(rd_log[1], 32'h1054, "R2 addr second");
    check(32'(wr_cnt - w0), 0, "R7 no write when used");

    va3 = va_of(4, 2, 0, 'h1ABCD);
    walk(va3, 0, 0, 32'h0079_ABCD, 2'd0, 2'd1, "R4 level B page");

    walk(va_of(20, 0, 0, 0), 0, 0, 0, 2'd1, 2'd0, "R3 invalid A");
    walk(va_of(3, 5, 9, 0), 0, 0, 0, 2'd1, 2'd2, "R3 invalid C");
    walk(va_of(3, 5, 10, 0), 0, 0, 0, 2'd1, 2'd2, "R3 table at C");

    vp = va_of(4, 3, 0, 'h100);
    w0 = wr_cnt;
    walk(vp, 0, 1, 0, 2'd2, 2'd1, "R5 protect");
    check(32'(wr_cnt - w0), 0, "R9 no write on fault");
    check(mem_rd(32'h500C), 32'h0077_000D, "R9 descriptor intact");
    walk(vp, 0, 0, 32'h0077_0100, 2'd0, 2'd1, "R5 read of protected");

    walk(va_of(6, 5, 7, 'h44), 0, 0, 0, 2'd3, 2'd0, "R6 privilege");
    walk(va_of(6, 5, 7, 'h44), 1, 0, 32'h00AB_C044, 2'd0, 2'd2, "R6 supervisor passes");
    walk(va_of(7, 5, 7, 0), 0, 1, 0, 2'd3, 2'd0, "R6 privilege over protect");
    walk(va_of(7, 5, 7, 0), 1, 1, 0, 2'd2, 2'd0, "R5 protect at A");

    w0 = wr_cnt;
    walk(va_of(11, 0, 0, 'h10), 0, 1, 32'h6000_0010, 2'd0, 2'd0, "R8 long page write");
    check(32'(wr_cnt - w0), 1, "R7 combined write");
    check(mem_rd(32'h1058), 32'h0000_0019, "R8 long page flags");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule